// File: doc/BRIEF.md
# Bus Master Security Filter

This block is placed on the path between a single bus-master device, for example a DMA engine, and the system interconnect. It decides for each request whether that request may proceed. The decision uses two inputs. The first is a pair of static configuration pins: one says whether the master counts as non-secure, and the other says how a refused request should be answered. The second is the result of an external address-attribution lookup, which reports whether the requested address belongs to secure space. The block has no register interface.

A request that passes the check goes to the downstream port with its address, write flag and write data unchanged. The downstream reply is then returned upstream. A request that fails the check never reaches downstream. The block answers it locally, either with an error response or as read-as-zero/write-ignored. Every refusal sets a sticky interrupt, which a clear input resets. Only one transaction is outstanding at a time. Both the upstream and downstream sides use valid/ready handshaking on requests. Responses are single-cycle valid pulses.

Top module: `msf_top`

## Requirements
- R1: A request that is accepted while `cfg_nonsec`=1 and `attr_secure`=1 is refused. No downstream request is issued for it, and exactly one upstream response follows in the cycle after acceptance.
- R2: Any other combination of `cfg_nonsec` and `attr_secure` is forwarded. In the cycle after acceptance, `dn_req_vld` rises, and `dn_wr`, `dn_addr` and `dn_wdata` equal the accepted upstream values. `dn_nonsec` equals `cfg_nonsec` as sampled at acceptance.
- R3: For a forwarded request, the upstream response pulses in the cycle after `dn_rsp_vld` is sampled. Its `up_rsp_rdata` and `up_rsp_err` equal the sampled `dn_rdata` and `dn_err`.
- R4: When a request is refused with `cfg_sec_resp`=1, the response has `up_rsp_err`=1 and `up_rsp_rdata`=0.
- R5: When a request is refused with `cfg_sec_resp`=0, the response has `up_rsp_err`=0 and `up_rsp_rdata`=0. This applies to reads and to writes. A refused write produces no downstream activity.
- R6: `up_req_rdy` is high only when no transaction is outstanding. Each accepted request gets exactly one `up_rsp_vld` pulse, one cycle long.
- R7: `irq` is 1 from the cycle after a refusal. It stays 1 until it is cleared, including across later forwarded transactions.
- R8: `irq_clr`=1 with no refusal in that cycle makes `irq` 0 in the next cycle. If `irq_clr` and a refusal happen in the same cycle, `irq` ends up at 1.
- R9: After reset, `irq`=0, `up_req_rdy`=1, and `dn_req_vld` and `up_rsp_vld` are both 0.
- R10: The attribution query address `attr_addr` follows `up_addr` in the same cycle.
- R11: While `dn_req_vld`=1 and `dn_req_rdy`=0, the downstream request and all its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nonsec | input | 1 | 1: the master is treated as non-secure |
| cfg_sec_resp | input | 1 | 1: refused requests return an error; 0: read-as-zero/write-ignored |
| up_req_vld | input | 1 | Upstream request valid |
| up_req_rdy | output | 1 | Upstream request ready (idle) |
| up_wr | input | 1 | Upstream write flag |
| up_addr | input | ADDR_W | Upstream address |
| up_wdata | input | DATA_W | Upstream write data |
| up_rsp_vld | output | 1 | Upstream response pulse |
| up_rsp_rdata | output | DATA_W | Upstream read data |
| up_rsp_err | output | 1 | Upstream error response |
| attr_addr | output | ADDR_W | Address sent to the attribution lookup |
| attr_secure | input | 1 | Lookup result: 1 means the address is secure |
| dn_req_vld | output | 1 | Downstream request valid |
| dn_req_rdy | input | 1 | Downstream request ready |
| dn_wr | output | 1 | Downstream write flag |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_nonsec | output | 1 | Security attribute of the forwarded request |
| dn_rsp_vld | input | 1 | Downstream response pulse |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_err | input | 1 | Downstream error response |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Sticky refusal interrupt |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a refusal. It needs an interrupt already pending, a refused request being accepted, and `irq_clr` raised exactly at that acceptance edge. The stimulus first refuses one request so that `irq` is set. It then issues a second refused request with `irq_clr` driven high only during the acceptance cycle. A sweep covers every combination of configuration pins, lookup result, direction and downstream stall length. Within it, the bench lookup marks addresses with the top bit set as secure.

// File: rtl/msf_pkg.sv
package msf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RSP  = 2'd3
  } msf_state_e;
endpackage

// File: rtl/msf_judge.sv
// Refusal decision: a non-secure master touching secure space is refused.
module msf_judge (
  input  logic master_nonsec,
  input  logic addr_secure,
  output logic refuse
);
  assign refuse = master_nonsec & addr_secure;
endmodule

// File: rtl/msf_irq.sv
// Sticky interrupt: a new refusal has priority over clear.
module msf_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr)     irq <= 1'b0;
  end
endmodule

// File: rtl/msf_ctrl.sv
module msf_ctrl
  import msf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              refuse,
  input  logic              err_on_refuse,
  input  logic              master_nonsec,
  output logic              refuse_evt,
  output logic              dn_vld,
  input  logic              dn_rdy,
  output logic              dn_wr,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_nonsec,
  input  logic              dn_rsp_vld,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  msf_state_e state_q;
  logic       accept;

  assign req_rdy    = (state_q == ST_IDLE);
  assign accept     = req_vld & req_rdy;
  assign refuse_evt = accept & refuse;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dn_vld    <= 1'b0;
      dn_wr     <= 1'b0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
      dn_nonsec <= 1'b0;
      rsp_vld   <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_vld <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (refuse) begin
              rsp_vld   <= 1'b1;
              rsp_rdata <= '0;
              rsp_err   <= err_on_refuse;
              state_q   <= ST_RSP;
            end else begin
              dn_vld    <= 1'b1;
              dn_wr     <= req_wr;
              dn_addr   <= req_addr;
              dn_wdata  <= req_wdata;
              dn_nonsec <= master_nonsec;
              state_q   <= ST_FWD;
            end
          end
        end
        ST_FWD: begin
          if (dn_rdy) begin
            dn_vld  <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dn_rsp_vld) begin
            rsp_vld   <= 1'b1;
            rsp_rdata <= dn_rdata;
            rsp_err   <= dn_err;
            state_q   <= ST_RSP;
          end
        end
        ST_RSP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msf_top.sv
module msf_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_nonsec,
  input  logic              cfg_sec_resp,
  input  logic              up_req_vld,
  output logic              up_req_rdy,
  input  logic              up_wr,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_rsp_vld,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              up_rsp_err,
  output logic [ADDR_W-1:0] attr_addr,
  input  logic              attr_secure,
  output logic              dn_req_vld,
  input  logic              dn_req_rdy,
  output logic              dn_wr,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_nonsec,
  input  logic              dn_rsp_vld,
  input  logic [DATA_W-1:0] dn_rdata,
  input  logic              dn_err,
  input  logic              irq_clr,
  output logic              irq
);
  logic refuse;
  logic refuse_evt;

  // The attribution query follows the live upstream address (R10).
  assign attr_addr = up_addr;

  msf_judge judge_i (
    .master_nonsec (cfg_nonsec),
    .addr_secure   (attr_secure),
    .refuse        (refuse)
  );

  msf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .req_vld       (up_req_vld),
    .req_rdy       (up_req_rdy),
    .req_wr        (up_wr),
    .req_addr      (up_addr),
    .req_wdata     (up_wdata),
    .refuse        (refuse),
    .err_on_refuse (cfg_sec_resp),
    .master_nonsec (cfg_nonsec),
    .refuse_evt    (refuse_evt),
    .dn_vld        (dn_req_vld),
    .dn_rdy        (dn_req_rdy),
    .dn_wr         (dn_wr),
    .dn_addr       (dn_addr),
    .dn_wdata      (dn_wdata),
    .dn_nonsec     (dn_nonsec),
    .dn_rsp_vld    (dn_rsp_vld),
    .dn_rdata      (dn_rdata),
    .dn_err        (dn_err),
    .rsp_vld       (up_rsp_vld),
    .rsp_rdata     (up_rsp_rdata),
    .rsp_err       (up_rsp_err)
  );

  msf_irq irq_i (
    .clk     (clk),
    .rst     (rst),
    .set_evt (refuse_evt),
    .clr     (irq_clr),
    .irq     (irq)
  );
endmodule

// File: rtl/msf_chk.sv
module msf_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_nonsec,
  input logic              cfg_sec_resp,
  input logic              attr_secure,
  input logic              up_req_vld,
  input logic              up_req_rdy,
  input logic              up_rsp_vld,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              dn_req_vld,
  input logic              dn_req_rdy,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              irq_clr,
  input logic              irq
);
  logic acc;
  logic bad;
  assign acc = up_req_vld & up_req_rdy;
  assign bad = acc & cfg_nonsec & attr_secure;

  // R1
  refuse_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> (!dn_req_vld && up_rsp_vld));

  // R4
  refuse_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bad && cfg_sec_resp) |=> (up_rsp_err && up_rsp_rdata == '0));

  // R5
  refuse_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (bad && !cfg_sec_resp) |=> (!up_rsp_err && up_rsp_rdata == '0));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    up_rsp_vld |=> !up_rsp_vld);

  // R6
  busy_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (up_rsp_vld || dn_req_vld) |-> !up_req_rdy);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> irq);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R8
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !bad) |=> !irq);

  // R11
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_req_vld && !dn_req_rdy) |=> (dn_req_vld && $stable(dn_addr) && $stable(dn_wdata)));
endmodule

bind msf_top msf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_nonsec   (cfg_nonsec),
  .cfg_sec_resp (cfg_sec_resp),
  .attr_secure  (attr_secure),
  .up_req_vld   (up_req_vld),
  .up_req_rdy   (up_req_rdy),
  .up_rsp_vld   (up_rsp_vld),
  .up_rsp_rdata (up_rsp_rdata),
  .up_rsp_err   (up_rsp_err),
  .dn_req_vld   (dn_req_vld),
  .dn_req_rdy   (dn_req_rdy),
  .dn_addr      (dn_addr),
  .dn_wdata     (dn_wdata),
  .irq_clr      (irq_clr),
  .irq          (irq)
);

// File: tb/msf_top_tb.sv
module msf_top_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_nonsec = 1'b0, cfg_sec_resp = 1'b0;
  logic up_req_vld = 1'b0, up_wr = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic up_req_rdy, up_rsp_vld, up_rsp_err;
  logic [DW-1:0] up_rsp_rdata;
  logic [AW-1:0] attr_addr;
  logic attr_secure;
  logic dn_req_vld, dn_wr, dn_nonsec;
  logic dn_req_rdy = 1'b0, dn_rsp_vld = 1'b0, dn_err = 1'b0;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [DW-1:0] dn_rdata = '0;
  logic irq_clr = 1'b0;
  logic irq;

  int total = 0;
  int bad = 0;
  logic exp_irq = 1'b0;

  always #2.5 clk = ~clk;

  // Bench lookup: top address bit set means secure space.
  assign attr_secure = attr_addr[AW-1];

  msf_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_nonsec(cfg_nonsec), .cfg_sec_resp(cfg_sec_resp),
    .up_req_vld(up_req_vld), .up_req_rdy(up_req_rdy), .up_wr(up_wr),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rsp_vld(up_rsp_vld),
    .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err), .attr_addr(attr_addr),
    .attr_secure(attr_secure), .dn_req_vld(dn_req_vld), .dn_req_rdy(dn_req_rdy),
    .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_nonsec(dn_nonsec),
    .dn_rsp_vld(dn_rsp_vld), .dn_rdata(dn_rdata), .dn_err(dn_err),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transaction; clr_at_acc raises irq_clr in the acceptance cycle.
  task automatic run_txn(input bit nonsec, input bit sresp, input bit sec, input bit wr,
                         input int stall, input bit clr_at_acc, input int idx);
    logic [AW-1:0] a;
    logic [DW-1:0] wd, rd;
    bit de, refuse;
    a  = {sec, 7'h12, idx[7:0], 16'h0040 + 16'(idx)};
    wd = 32'hA5000000 ^ idx;
    rd = 32'h3C3C0000 + idx;
    de = idx[0];
    refuse = nonsec & sec;
    @(negedge clk);
    cfg_nonsec = nonsec; cfg_sec_resp = sresp;
    up_req_vld = 1'b1; up_wr = wr; up_addr = a; up_wdata = wd;
    irq_clr = clr_at_acc;
    #0.5;
    // R10
    check(attr_addr == a, "R10", attr_addr, a);
    // R6
    check(up_req_rdy == 1'b1, "R6 idle rdy", up_req_rdy, 1);
    @(negedge clk);
    up_req_vld = 1'b0; irq_clr = 1'b0;
    if (refuse) exp_irq = 1'b1;
    else if (clr_at_acc) exp_irq = 1'b0;
    if (refuse) begin
      // R1
      check(dn_req_vld == 1'b0 && up_rsp_vld == 1'b1, "R1", {dn_req_vld, up_rsp_vld}, 2'b01);
      if (sresp)
        // R4
        check(up_rsp_err == 1'b1 && up_rsp_rdata == '0, "R4", {up_rsp_err, up_rsp_rdata}, {1'b1, 32'h0});
      else
        // R5
        check(up_rsp_err == 1'b0 && up_rsp_rdata == '0, "R5", {up_rsp_err, up_rsp_rdata}, 33'h0);
      // R7 / R8
      check(irq == exp_irq, clr_at_acc ? "R8 refuse beats clear" : "R7", irq, exp_irq);
    end else begin
      // R2
      check(dn_req_vld && dn_addr == a && dn_wdata == wd && dn_wr == wr && dn_nonsec == nonsec,
            "R2", {dn_req_vld, dn_wr, dn_nonsec, dn_addr}, {1'b1, wr, nonsec, a});
      check(up_rsp_vld == 1'b0, "R6 no early rsp", up_rsp_vld, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        // R11
        check(dn_req_vld && dn_addr == a && dn_wdata == wd, "R11", {dn_req_vld, dn_addr}, {1'b1, a});
        check(up_req_rdy == 1'b0, "R6 busy", up_req_rdy, 0);
      end
      dn_req_rdy = 1'b1;
      @(negedge clk);
      dn_req_rdy = 1'b0;
      check(dn_req_vld == 1'b0, "R2 single issue", dn_req_vld, 0);
      for (int s = 0; s < stall; s++) @(negedge clk);
      dn_rsp_vld = 1'b1; dn_rdata = rd; dn_err = de;
      @(negedge clk);
      dn_rsp_vld = 1'b0;
      // R3
      check(up_rsp_vld && up_rsp_rdata == rd && up_rsp_err == de, "R3",
            {up_rsp_vld, up_rsp_err, up_rsp_rdata}, {1'b1, de, rd});
      // R7: irq unaffected by forwarded traffic
      check(irq == exp_irq, "R7 hold", irq, exp_irq);
    end
    @(negedge clk);
    // R6
    check(up_rsp_vld == 1'b0 && up_req_rdy == 1'b1, "R6 one rsp", {up_rsp_vld, up_req_rdy}, 2'b01);
  endtask

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.5;
    // R9
    check(irq == 0 && up_req_rdy == 1 && dn_req_vld == 0 && up_rsp_vld == 0, "R9",
          {irq, up_req_rdy, dn_req_vld, up_rsp_vld}, 4'b0100);
    for (int ns = 0; ns < 2; ns++)
      for (int sr = 0; sr < 2; sr++)
        for (int sc = 0; sc < 2; sc++)
          for (int w = 0; w < 2; w++)
            for (int st = 0; st < 3; st++) begin
              run_txn(ns[0], sr[0], sc[0], w[0], st, 1'b0, n);
              n++;
            end
    // R8: plain clear
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; exp_irq = 1'b0;
    check(irq == 1'b0, "R8 clear", irq, 0);
    // R7: refuse then stays sticky over idle cycles
    run_txn(1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0, 77);
    repeat (4) @(negedge clk);
    check(irq == 1'b1, "R7 sticky", irq, 1);
    // R8: clear coincident with a refusal
    run_txn(1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1, 78);
    // clear coincident with a forwarded accept clears
    run_txn(1'b0, 1'b0, 1'b1, 1'b0, 1, 1'b1, 79);
    check(irq == 1'b0, "R8 clear on forward", irq, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule